// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block evaluates one integer operation on two operands and reports the result with six status flags: carry, overflow, sign, zero, auxiliary carry and parity. It supports seven operations: add, add with carry, subtract, subtract with borrow, AND, OR and XOR. Each operation runs at a selectable width of 8, 16 or 32 bits. The carry input is used only by the two with-carry operations.

Operands and results travel over a valid/ready stream. With the default output register (`REG_OUT = 1`), an operation accepted on a clock edge appears at the output after that edge. The output holds steady for as long as the consumer keeps `out_ready` low. The input is ready whenever the output slot is empty or is being drained in the same cycle. With `REG_OUT = 0`, the block is purely combinational, and both handshakes pass straight through.

Operation codes on `in_op`: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 null (logical, result zero). Width codes on `in_size`: 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits.

Top module: `flag_gen`

## Requirements
- R1: Codes 0 and 1 return (a + b + carry-in) modulo 2^W on the selected width W, where the carry-in term counts only for code 1.
- R2: Codes 2 and 3 return (a - b - borrow-in) modulo 2^W, where the borrow-in term counts only for code 3; out_cf is 1 exactly when a < b + borrow-in, compared unsigned.
- R3: For codes 0 and 1, out_cf is 1 when the unsigned sum exceeds 2^W - 1.
- R4: For codes 0 to 3, out_of is 1 when the exact signed two's complement result lies outside [-2^(W-1), 2^(W-1) - 1].
- R5: out_sf equals result bit W-1, and out_zf is 1 exactly when the W result bits are all zero.
- R6: For codes 0 to 3, out_af is 1 when a carry (or a borrow) crosses from bit 3 into bit 4, at every width.
- R7: out_pf is 1 when result bits 7:0 hold an even number of ones, at every width.
- R8: Codes 4, 5 and 6 return a AND b, a OR b and a XOR b, and code 7 returns zero. All four clear out_cf, out_of and out_af.
- R9: in_size 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Operand bits above W are ignored, and result bits above W are driven to zero.
- R10: An operation accepted on an edge (in_valid and in_ready both high) is presented with out_valid high after that edge. A presented result stays unchanged while out_ready is low. in_ready is high when out_valid is low or out_ready is high. Results leave in acceptance order.
- R11: After reset, out_valid is low and in_ready is high.
- R12: in_cin has no effect on codes 0, 2, 4, 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_op | input | 3 | Operation code |
| in_size | input | 2 | Width code |
| in_cin | input | 1 | Carry or borrow input |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 32 | Result, zero above the selected width |
| out_cf | output | 1 | Carry / borrow flag |
| out_of | output | 1 | Signed overflow flag |
| out_sf | output | 1 | Sign flag |
| out_zf | output | 1 | Zero flag |
| out_af | output | 1 | Auxiliary carry flag |
| out_pf | output | 1 | Parity flag (low byte) |

## Verification
Two things can fall in the same cycle: a new operation can be accepted on the very edge where the held result is drained, and a stalled output can coexist with a pending input. The bench provokes both by randomising `out_ready` against a mostly busy `in_valid`. It holds an offered input stable until it is taken. A queue-based behavioural model, fed on every input handshake and popped on every output handshake, judges the results, and their order shows that nothing was lost or duplicated. Stalled cycles are compared against the previous cycle's outputs. Directed boundary operands, such as sign-crossing and carry-out sums, borrows, nibble carries, garbage upper bits and a set carry-in on operations that ignore it, precede the random traffic.

// File: rtl/fg_pkg.sv
package fg_pkg;
  localparam int unsigned FG_W = 32;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBB = 3'd3,
    OP_AND = 3'd4, OP_OR  = 3'd5, OP_XOR = 3'd6, OP_NUL = 3'd7
  } fg_op_e;

  typedef enum logic [1:0] {
    SZ_8 = 2'd0, SZ_16 = 2'd1, SZ_32 = 2'd2, SZ_32X = 2'd3
  } fg_size_e;

  typedef struct packed {
    logic cf;
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
  } fg_flags_t;

  typedef struct packed {
    logic [FG_W-1:0] res;
    fg_flags_t       fl;
  } fg_word_t;
endpackage

// File: rtl/fg_arith.sv
module fg_arith
  import fg_pkg::*;
#(
  parameter int unsigned W = FG_W
) (
  input  logic [W-1:0] a_m,
  input  logic [W-1:0] b_m,
  input  logic [W-1:0] mask,
  input  fg_size_e     size,
  input  logic         is_sub,
  input  logic         cin_eff,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         ovf,
  output logic         aux
);
  logic [W:0] sum_x, dif_x, raw;
  logic       a_top, b_top, r_top;

  always_comb begin
    sum_x = {1'b0, a_m} + {1'b0, b_m} + {{W{1'b0}}, cin_eff};
    dif_x = {1'b0, a_m} - {1'b0, b_m} - {{W{1'b0}}, cin_eff};
    raw   = is_sub ? dif_x : sum_x;
    res   = raw[W-1:0] & mask;
    case (size)
      SZ_8:    begin a_top = a_m[7];   b_top = b_m[7];   r_top = res[7];
                     carry = is_sub ? dif_x[W] : sum_x[8];  end
      SZ_16:   begin a_top = a_m[15];  b_top = b_m[15];  r_top = res[15];
                     carry = is_sub ? dif_x[W] : sum_x[16]; end
      default: begin a_top = a_m[W-1]; b_top = b_m[W-1]; r_top = res[W-1];
                     carry = raw[W]; end
    endcase
    // signed overflow: operand signs vs result sign
    ovf = (is_sub ? (a_top != b_top) : (a_top == b_top)) && (r_top != a_top);
    // carry or borrow into bit 4 recovered from the bit-4 sum
    aux = a_m[4] ^ b_m[4] ^ res[4];
  end
endmodule

// File: rtl/fg_logic.sv
module fg_logic
  import fg_pkg::*;
#(
  parameter int unsigned W = FG_W
) (
  input  logic [W-1:0] a_m,
  input  logic [W-1:0] b_m,
  input  fg_op_e       op,
  output logic [W-1:0] res
);
  always_comb begin
    case (op)
      OP_AND:  res = a_m & b_m;
      OP_OR:   res = a_m | b_m;
      OP_XOR:  res = a_m ^ b_m;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/fg_stage.sv
module fg_stage
  import fg_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     up_valid,
  output logic     up_ready,
  input  fg_word_t up_word,
  output logic     dn_valid,
  input  logic     dn_ready,
  output fg_word_t dn_word
);
  generate
    if (REG_OUT) begin : g_reg
      logic     full_q;
      fg_word_t word_q;
      assign up_ready = !full_q || dn_ready;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          full_q <= 1'b0;
          word_q <= '0;
        end else if (up_ready) begin
          full_q <= up_valid;
          if (up_valid) word_q <= up_word;
        end
      end
      assign dn_valid = full_q;
      assign dn_word  = word_q;
    end else begin : g_thru
      assign up_ready = dn_ready;
      assign dn_valid = up_valid;
      assign dn_word  = up_word;
    end
  endgenerate
endmodule

// File: rtl/flag_gen.sv
module flag_gen
  import fg_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_a,
  input  logic [31:0] in_b,
  input  logic [2:0]  in_op,
  input  logic [1:0]  in_size,
  input  logic        in_cin,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_res,
  output logic        out_cf,
  output logic        out_of,
  output logic        out_sf,
  output logic        out_zf,
  output logic        out_af,
  output logic        out_pf
);
  localparam int unsigned W = FG_W;

  fg_op_e     op;
  fg_size_e   size;
  logic [W-1:0] mask, a_m, b_m, ar_res, lg_res, res;
  logic       is_logic, ar_cf, ar_of, ar_af, msb;
  fg_word_t   word, dn_word;

  assign op       = fg_op_e'(in_op);
  assign size     = fg_size_e'(in_size);
  assign is_logic = in_op[2];

  always_comb begin
    case (size)
      SZ_8:    mask = W'(32'h0000_00FF);
      SZ_16:   mask = W'(32'h0000_FFFF);
      default: mask = '1;
    endcase
  end

  assign a_m = in_a & mask;
  assign b_m = in_b & mask;

  fg_arith #(.W(W)) u_arith (
    .a_m(a_m), .b_m(b_m), .mask(mask), .size(size),
    .is_sub(in_op[1]), .cin_eff(in_op[0] & in_cin),
    .res(ar_res), .carry(ar_cf), .ovf(ar_of), .aux(ar_af)
  );

  fg_logic #(.W(W)) u_logic (
    .a_m(a_m), .b_m(b_m), .op(op), .res(lg_res)
  );

  assign res = is_logic ? lg_res : ar_res;

  always_comb begin
    case (size)
      SZ_8:    msb = res[7];
      SZ_16:   msb = res[15];
      default: msb = res[W-1];
    endcase
    word.res   = res;
    word.fl.cf = !is_logic && ar_cf;
    word.fl.of = !is_logic && ar_of;
    word.fl.af = !is_logic && ar_af;
    word.fl.sf = msb;
    word.fl.zf = (res == '0);
    word.fl.pf = ~^res[7:0];
  end

  fg_stage #(.REG_OUT(REG_OUT)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_word(word),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_word(dn_word)
  );

  assign out_res = dn_word.res;
  assign out_cf  = dn_word.fl.cf;
  assign out_of  = dn_word.fl.of;
  assign out_sf  = dn_word.fl.sf;
  assign out_zf  = dn_word.fl.zf;
  assign out_af  = dn_word.fl.af;
  assign out_pf  = dn_word.fl.pf;
endmodule

// File: rtl/flag_gen_chk.sv
module flag_gen_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [2:0]  in_op,
  input logic [1:0]  in_size,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_res,
  input logic        out_cf,
  input logic        out_of,
  input logic        out_sf,
  input logic        out_zf,
  input logic        out_af,
  input logic        out_pf
);
  logic       seen_logic;
  logic [1:0] seen_size;

  generate
    if (REG_OUT) begin : g_track
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          seen_logic <= 1'b0;
          seen_size  <= 2'd2;
        end else if (in_valid && in_ready) begin
          seen_logic <= in_op[2];
          seen_size  <= in_size;
        end
      end

      // R10
      accept_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

      // R10
      stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_res) &&
          $stable({out_cf, out_of, out_sf, out_zf, out_af, out_pf}));
    end else begin : g_comb
      assign seen_logic = in_op[2];
      assign seen_size  = in_size;
    end
  endgenerate

  // R8
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && seen_logic |-> !out_cf && !out_of && !out_af);

  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && seen_size == 2'd0 |-> out_res[31:8] == 24'd0);

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_zf == (out_res == 32'd0));

  // R7
  parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_pf == ~^out_res[7:0]);
endmodule

bind flag_gen flag_gen_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_size(in_size), .out_valid(out_valid),
  .out_ready(out_ready), .out_res(out_res), .out_cf(out_cf),
  .out_of(out_of), .out_sf(out_sf), .out_zf(out_zf), .out_af(out_af),
  .out_pf(out_pf)
);

// File: tb/tb_flag_gen.sv
`timescale 1ns/1ps
module tb_flag_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [31:0] in_a = '0, in_b = '0;
  logic [2:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic        in_cin = 1'b0;
  logic        out_valid, out_ready = 1'b0;
  logic [31:0] out_res;
  logic        out_cf, out_of, out_sf, out_zf, out_af, out_pf;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flag_gen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_op(in_op), .in_size(in_size),
    .in_cin(in_cin), .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_cf(out_cf), .out_of(out_of), .out_sf(out_sf),
    .out_zf(out_zf), .out_af(out_af), .out_pf(out_pf)
  );

  typedef struct {
    logic [31:0] res;
    logic [5:0]  fl;
    logic [2:0]  op;
    logic [1:0]  sz;
    logic        cin;
  } exp_t;

  exp_t q[$];

  function automatic exp_t model(logic [31:0] a, logic [31:0] b,
                                 logic [2:0] op, logic [1:0] sz, logic cin);
    exp_t e;
    int w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    longint m = (longint'(1) << w) - 1;
    longint half = longint'(1) << (w - 1);
    longint am = longint'(a) & m, bm = longint'(b) & m;
    longint c = ((op == 3'd1 || op == 3'd3) && cin) ? 1 : 0;
    longint sa = (am >= half) ? am - 2 * half : am;
    longint sb = (bm >= half) ? bm - 2 * half : bm;
    longint r = 0, sr = 0;
    bit cf = 0, of = 0, af = 0;
    int ones = 0;
    case (op)
      3'd0, 3'd1: begin
        r = am + bm + c; cf = (r > m); sr = sa + sb + c;
        of = (sr >= half) || (sr < -half);
        af = ((am & 15) + (bm & 15) + c) > 15;
      end
      3'd2, 3'd3: begin
        r = am - bm - c; cf = (r < 0); sr = sa - sb - c;
        of = (sr >= half) || (sr < -half);
        af = (am & 15) < ((bm & 15) + c);
      end
      3'd4: r = am & bm;
      3'd5: r = am | bm;
      3'd6: r = am ^ bm;
      default: r = 0;
    endcase
    r = r & m;
    for (int i = 0; i < 8; i++) ones += int'((r >> i) & 1);
    e.res = r[31:0];
    e.fl  = {cf, of, (r >= half), (r == 0), af, (ones % 2 == 0)};
    e.op = op; e.sz = sz; e.cin = cin;
    return e;
  endfunction

  function automatic string rtag(exp_t e);
    string s = (e.op < 3'd2) ? "R1" : (e.op < 3'd4) ? "R2" : "R8";
    if (e.sz != 2'd2) s = {s, " R9"};
    if (e.cin && e.op != 3'd1 && e.op != 3'd3) s = {s, " R12"};
    return s;
  endfunction

  task automatic compare(exp_t e);
    logic [5:0] got = {out_cf, out_of, out_sf, out_zf, out_af, out_pf};
    string ar = (e.op < 3'd4) ? "" : " R8";
    n_chk++;
    if (out_res !== e.res || got !== e.fl) begin
      n_bad++;
      if (out_res !== e.res)
        $display("FAIL %s result op%0d sz%0d: got %h exp %h", rtag(e), e.op, e.sz, out_res, e.res);
      if (got[5] !== e.fl[5])
        $display("FAIL %s CF: got %b exp %b", (e.op < 2) ? "R3" : (e.op < 4) ? "R2" : "R8", got[5], e.fl[5]);
      if (got[4] !== e.fl[4]) $display("FAIL R4%s OF: got %b exp %b", ar, got[4], e.fl[4]);
      if (got[3] !== e.fl[3]) $display("FAIL R5 SF: got %b exp %b", got[3], e.fl[3]);
      if (got[2] !== e.fl[2]) $display("FAIL R5 ZF: got %b exp %b", got[2], e.fl[2]);
      if (got[1] !== e.fl[1]) $display("FAIL R6%s AF: got %b exp %b", ar, got[1], e.fl[1]);
      if (got[0] !== e.fl[0]) $display("FAIL R7 PF: got %b exp %b", got[0], e.fl[0]);
    end
  endtask

  task automatic directed(int k, output logic [31:0] a, output logic [31:0] b,
                          output logic [2:0] op, output logic [1:0] sz, output logic c);
    c = 1'b0;
    case (k)
      0:  begin a = 32'hFFFF_FFFF; b = 32'h1;   op = 0; sz = 0; end // R3 8-bit wrap, garbage high bits
      1:  begin a = 32'h7F;        b = 32'h1;   op = 0; sz = 0; end // R4 signed overflow
      2:  begin a = 32'h80;        b = 32'h1;   op = 2; sz = 0; end // R4 sub overflow
      3:  begin a = 32'h0;         b = 32'h1;   op = 2; sz = 1; end // R2 borrow
      4:  begin a = 32'hFFFF;      b = 32'h0;   op = 1; sz = 1; c = 1; end // R1 carry-in
      5:  begin a = 32'h5;         b = 32'h5;   op = 3; sz = 2; c = 1; end // R2 borrow-in
      6:  begin a = 32'h0F;        b = 32'h1;   op = 0; sz = 2; end // R6 nibble carry
      7:  begin a = 32'h10;        b = 32'h1;   op = 2; sz = 3; end // R6 nibble borrow, R9 size 3
      8:  begin a = 32'hDEAD_BEEF; b = 32'hFFFF; op = 4; sz = 1; c = 1; end // R8 R12
      9:  begin a = 32'h1234_5678; b = 32'h8765_4321; op = 7; sz = 2; end // R8 null
      10: begin a = 32'h8000_0000; b = 32'h8000_0000; op = 0; sz = 2; c = 1; end // R12
      11: begin a = 32'hAB00_0003; b = 32'h0000_0003; op = 2; sz = 0; c = 1; end // R5 zero, R12
      12: begin a = 32'h7FFF_FFFF; b = 32'hFFFF_FFFF; op = 3; sz = 2; c = 1; end
      default: begin a = 32'h0F0F_00FF; b = 32'h00F0_0F01; op = 6; sz = 2; end // R7
    endcase
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog expired: got hang exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    bit pend = 1'b0, was_stall = 1'b0;
    logic [37:0] held = '0;
    logic [31:0] a, b; logic [2:0] op; logic [1:0] sz; logic c;
    exp_t e;
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    n_chk++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R11 reset: got valid %b ready %b exp 0 1", out_valid, in_ready);
    end
    @(negedge clk); rst_n = 1'b1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      if (!pend) begin
        if (cyc < 14) begin directed(cyc, a, b, op, sz, c); in_valid = 1'b1; end
        else begin
          a = $urandom; b = $urandom; op = 3'($urandom); sz = 2'($urandom);
          c = 1'($urandom);
          if ($urandom_range(3) == 0) b = a;
          in_valid = ($urandom_range(9) < 8);
        end
        in_a = a; in_b = b; in_op = op; in_size = sz; in_cin = c;
      end
      if (cyc >= 3500) in_valid = 1'b0;
      out_ready = (cyc >= 3500) ? 1'b1 : ($urandom_range(9) < 6);
      #1;
      if (was_stall) begin
        n_chk++;
        if ({out_valid, out_res, out_cf, out_of, out_sf, out_zf, out_af, out_pf} !==
            {1'b1, held}) begin
          n_bad++;
          $display("FAIL R10 stall hold: got %h exp %h",
                   {out_res, out_cf, out_of, out_sf, out_zf, out_af, out_pf}, held);
        end
      end
      was_stall = out_valid && !out_ready;
      held = {out_res, out_cf, out_of, out_sf, out_zf, out_af, out_pf};
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R10 unexpected output: got %h exp none", out_res);
        end else begin
          e = q.pop_front();
          compare(e);
        end
      end
      if (in_valid && in_ready) q.push_back(model(in_a, in_b, in_op, in_size, in_cin));
      pend = in_valid && !in_ready;
    end
    n_chk++;
    if (q.size() != 0 || out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 drain: got %0d pending valid %b exp 0 0", q.size(), out_valid);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule